// File: doc/BRIEF.md
# Batched Sector Erase Window Controller

This block gathers sector erase requests for a flash array and launches one combined erase once an acceptance window closes. An upstream command decoder signals that the unlock and erase-setup prefix has been received. From then on, each confirming write (data 30h) names a sector through any address that falls inside it. That sector joins a pending set, and the acceptance timer restarts.

When the timer runs out without a new confirming write, the pending set is filtered through the protection mask and handed to the array as an erase mask for a fixed erase period. If every requested sector is protected, the block only stays busy for a short fixed period and erases nothing. A write with any other data during the window cancels the whole batch. While an erase runs, the block ignores further commands. Reads from a sector being erased see a low polling bit.

Top module: `sect_erase_batch`

## Requirements
- R1: After reset, and at once when reset is asserted at any time (including mid-erase), `busy`=0, `tmr_active`=0, `erase_mask`=0 and `poll_dq7`=1.
- R2: After `setup_ok`, a write whose data is 30h arms the window. `tmr_active` is high for exactly WIN_CYC cycles after the write's rising strobe edge. Then `busy` rises and `erase_mask` holds the selected sectors.
- R3: Each further 30h write during the window adds its sector to the set and restarts the full WIN_CYC window from that write.
- R4: A sector whose bit is set in `prot_mask` when the window expires is left out of `erase_mask`.
- R5: If all selected sectors are protected, `busy` stays high for PROT_CYC cycles with `erase_mask`=0, and then the block returns to read mode.
- R6: An erase keeps `busy` high and `erase_mask` steady for exactly ERASE_CYC cycles. Afterwards both clear, and a new `setup_ok` is needed before the next batch.
- R7: A write with data other than 30h during the window drops `tmr_active` and clears the pending set. No erase follows, and the next batch contains only its own sectors.
- R8: Writes and `setup_ok` during an erase are ignored. The mask and the erase duration are unchanged, and no new window opens afterwards.
- R9: `poll_dq7` is 0 only while erasing with `addr` inside a sector of `erase_mask`. Otherwise it is 1, including during the window.
- R10: The sector index is the top log2(NUM_SECT) bits of `addr`, taken on the falling edge of `we_n`. Changes to `addr` while `we_n` stays low have no effect.
- R11: Writes are ignored unless `setup_ok` came first. A non-30h write after `setup_ok` disarms the block, so a following 30h write opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_n | input | 1 | Bus write strobe, active low, synchronous to clk |
| addr | input | ADDR_W | Bus address; upper bits select the sector |
| wdata | input | DATA_W | Bus write data, taken at strobe rising edge |
| setup_ok | input | 1 | One-cycle pulse: erase command prefix decoded upstream |
| prot_mask | input | NUM_SECT | Per-sector protection, 1 = protected |
| erase_mask | output | NUM_SECT | Sectors being erased |
| busy | output | 1 | Erase (or protected no-op) in progress |
| tmr_active | output | 1 | Acceptance window running |
| poll_dq7 | output | 1 | Polling status bit for reads at `addr` |

## Verification
The hardest case to reach is the restart of the acceptance timer late in the window. The second confirming write has to land a few cycles before expiry, and the next window must then be measured from that write and not from the first. The stimulus holds off the second write until WIN_CYC-5 cycles have passed. It checks that the timer is still active at that point, and then counts the active cycles after the second write. Commands issued in the middle of an erase are injected while the busy cycles are counted, so that any stretched or restarted erase shows up as a wrong count.

// File: rtl/seb_pkg.sv
package seb_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_ARMED = 3'd1,
    ST_ACCUM = 3'd2,
    ST_ERASE = 3'd3,
    ST_PROT  = 3'd4
  } seb_state_e;
endpackage

// File: rtl/seb_strobe.sv
module seb_strobe #(
  parameter int SB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [SB-1:0] sec_in,
  output logic [SB-1:0] sec_lat,
  output logic          wr_done
);
  logic          we_q;
  logic          fall;
  logic [SB-1:0] sec_d;

  assign fall    = we_q & ~we_n;
  assign wr_done = ~we_q & we_n;

  always_comb begin
    sec_d = sec_lat;
    if (fall) sec_d = sec_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      sec_lat <= '0;
    end else begin
      we_q    <= we_n;
      sec_lat <= sec_d;
    end
  end
endmodule

// File: rtl/seb_timer.sv
module seb_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seb_sectors.sv
module seb_sectors #(
  parameter int NS = 8,
  parameter int SB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [SB-1:0] set_idx,
  input  logic          clr,
  input  logic          snap,
  input  logic [NS-1:0] prot,
  output logic [NS-1:0] pend,
  output logic [NS-1:0] act
);
  logic [NS-1:0] pend_d, act_d;

  for (genvar g = 0; g < NS; g++) begin : g_sect
    always_comb begin
      pend_d[g] = pend[g];
      if (clr)                                     pend_d[g] = 1'b0;
      else if (set_en && (set_idx == SB'(g)))      pend_d[g] = 1'b1;
      act_d[g] = act[g];
      if (clr)       act_d[g] = 1'b0;
      else if (snap) act_d[g] = pend[g] & ~prot[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      pend <= pend_d;
      act  <= act_d;
    end
  end
endmodule

// File: rtl/sect_erase_batch.sv
module sect_erase_batch
  import seb_pkg::*;
#(
  parameter int              NUM_SECT  = 8,
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              WIN_CYC   = 20000,
  parameter int              ERASE_CYC = 64,
  parameter int              PROT_CYC  = 4,
  parameter logic [DATA_W-1:0] CONFIRM = 8'h30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                setup_ok,
  input  logic [NUM_SECT-1:0] prot_mask,
  output logic [NUM_SECT-1:0] erase_mask,
  output logic                busy,
  output logic                tmr_active,
  output logic                poll_dq7
);
  localparam int SB    = $clog2(NUM_SECT);
  localparam int MAXC  = (WIN_CYC > ERASE_CYC) ?
                         ((WIN_CYC > PROT_CYC) ? WIN_CYC : PROT_CYC) :
                         ((ERASE_CYC > PROT_CYC) ? ERASE_CYC : PROT_CYC);
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WIN_LD = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] ERS_LD = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] PRT_LD = CW'(PROT_CYC - 1);

  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic [SB-1:0]       sec_in, sec_lat, sec_rd;
  logic                wr_done, cmd_hit;
  logic                t_load, t_zero;
  logic [CW-1:0]       t_val;
  logic                set_en, clr, snap;
  logic [NUM_SECT-1:0] pend, act, live;
  seb_state_e          state_q, state_d;
  logic                unused_low;

  assign sec_in     = addr[ADDR_W-1 -: SB];
  assign sec_rd     = addr[ADDR_W-1 -: SB];
  assign unused_low = ^addr[ADDR_W-SB-1:0];
  assign cmd_hit    = wr_done && (wdata == CONFIRM);
  assign live       = pend & ~prot_mask;

  seb_strobe #(.SB(SB)) u_strobe (
    .clk(clk), .rst_n(rst_s), .we_n(we_n), .sec_in(sec_in),
    .sec_lat(sec_lat), .wr_done(wr_done)
  );

  seb_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_s), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  seb_sectors #(.NS(NUM_SECT), .SB(SB)) u_sect (
    .clk(clk), .rst_n(rst_s), .set_en(set_en), .set_idx(sec_lat),
    .clr(clr), .snap(snap), .prot(prot_mask), .pend(pend), .act(act)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    set_en  = 1'b0;
    clr     = 1'b0;
    snap    = 1'b0;
    case (state_q)
      ST_READ: begin
        if (setup_ok) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (cmd_hit) begin
          state_d = ST_ACCUM;
          set_en  = 1'b1;
          t_load  = 1'b1;
          t_val   = WIN_LD;
        end else if (wr_done) begin
          state_d = ST_READ;
        end
      end
      ST_ACCUM: begin
        if (cmd_hit) begin
          set_en = 1'b1;
          t_load = 1'b1;
          t_val  = WIN_LD;
        end else if (wr_done) begin
          clr     = 1'b1;
          state_d = ST_READ;
        end else if (t_zero) begin
          snap   = 1'b1;
          t_load = 1'b1;
          if (|live) begin
            state_d = ST_ERASE;
            t_val   = ERS_LD;
          end else begin
            state_d = ST_PROT;
            t_val   = PRT_LD;
          end
        end
      end
      ST_ERASE, ST_PROT: begin
        if (t_zero) begin
          clr     = 1'b1;
          state_d = ST_READ;
        end
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) state_q <= ST_READ;
    else        state_q <= state_d;
  end

  assign busy       = (state_q == ST_ERASE) || (state_q == ST_PROT);
  assign tmr_active = (state_q == ST_ACCUM);
  assign erase_mask = (state_q == ST_ERASE) ? act : '0;
  assign poll_dq7   = !((state_q == ST_ERASE) && act[sec_rd]);
endmodule

// File: rtl/seb_checker.sv
module seb_checker #(
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          tmr_active,
  input logic          poll_dq7,
  input logic [NS-1:0] erase_mask
);
  p_mask_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (erase_mask == '0));

  p_mask_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (erase_mask == $past(erase_mask)));

  p_erase_after_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tmr_active));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && tmr_active));

  p_poll_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_dq7 |-> busy);
endmodule

bind sect_erase_batch seb_checker #(.NS(NUM_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tmr_active(tmr_active),
  .poll_dq7(poll_dq7), .erase_mask(erase_mask)
);

// File: tb/sect_erase_batch_tb.sv
`timescale 1ns/1ps
module sect_erase_batch_tb;
  localparam int W = 40;
  localparam int E = 20;
  localparam int P = 5;

  typedef struct packed {
    logic [7:0] sel;
    logic [7:0] prot;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'h01, 8'h00, 8'h01},
    '{8'h80, 8'h00, 8'h80},
    '{8'h24, 8'h00, 8'h24},
    '{8'h0F, 8'h02, 8'h0D},
    '{8'h30, 8'h30, 8'h00},
    '{8'hFF, 8'h81, 8'h7E}
  };

  logic        clk, rst_n, we_n, setup_ok;
  logic [15:0] addr;
  logic [7:0]  wdata, prot;
  logic [7:0]  erase_mask;
  logic        busy, tmr_active, poll_dq7;
  int n_run = 0, n_fail = 0, bcnt;

  sect_erase_batch #(.NUM_SECT(8), .ADDR_W(16), .DATA_W(8), .WIN_CYC(W),
                     .ERASE_CYC(E), .PROT_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .setup_ok(setup_ok), .prot_mask(prot), .erase_mask(erase_mask),
    .busy(busy), .tmr_active(tmr_active), .poll_dq7(poll_dq7)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sa(input int s);
    return {s[2:0], 13'h0AB};
  endfunction

  task automatic arm();
    @(negedge clk); setup_ok = 1'b1;
    @(negedge clk); setup_ok = 1'b0;
  endtask

  task automatic write_cmd(input int s, input logic [7:0] d);
    @(negedge clk); addr = sa(s); we_n = 1'b0;
    @(negedge clk); wdata = d; we_n = 1'b1;
  endtask

  task automatic measure(output int tcnt, output int bc, output logic [7:0] m);
    tcnt = 0; bc = 0;
    @(negedge clk);
    while (tmr_active === 1'b1 && tcnt < 1000) begin tcnt++; @(negedge clk); end
    m = erase_mask;
    while (busy === 1'b1 && bc < 1000) begin bc++; @(negedge clk); end
  endtask

  task automatic tick();
    @(negedge clk);
    if (busy) bcnt++;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int tc, bc, quiet;
    logic [7:0] m;
    rst_n = 1'b0; we_n = 1'b1; setup_ok = 1'b0; addr = '0; wdata = '0; prot = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset mask", erase_mask, 0);
    chk("R1 reset poll", poll_dq7, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release timer", tmr_active, 0);

    for (int v = 0; v < 6; v++) begin
      prot = VEC[v].prot;
      arm();
      for (int s = 0; s < 8; s++) if (VEC[v].sel[s]) write_cmd(s, 8'h30);
      measure(tc, bc, m);
      chk("R2/R3 window length", tc, W);
      chk("R4 erase mask", m, VEC[v].exp);
      if (VEC[v].exp == 8'h00) chk("R5 protected busy", bc, P);
      else                     chk("R6 erase length", bc, E);
      chk("R6 mask clear after", erase_mask, 0);
      repeat (2) @(negedge clk);
    end
    prot = '0;

    // R11: no arm, then disarm by foreign data
    write_cmd(1, 8'h30);
    repeat (3) @(negedge clk);
    chk("R11 unarmed write ignored", tmr_active, 0);
    arm();
    write_cmd(1, 8'h55);
    @(negedge clk);
    chk("R11 foreign data no window", tmr_active, 0);
    write_cmd(1, 8'h30);
    repeat (2) @(negedge clk);
    chk("R11 disarmed stays read", tmr_active, 0);

    // R10: address change while strobe low
    arm();
    @(negedge clk); addr = sa(4); we_n = 1'b0;
    @(negedge clk); addr = sa(6);
    @(negedge clk); wdata = 8'h30; we_n = 1'b1;
    measure(tc, bc, m);
    chk("R10 sector from falling edge", m, 8'h10);

    // R7: abort then fresh batch
    arm();
    write_cmd(1, 8'h30);
    write_cmd(2, 8'hF0);
    @(negedge clk);
    chk("R7 abort drops timer", tmr_active, 0);
    quiet = 0;
    repeat (W + 5) begin @(negedge clk); if (busy) quiet++; end
    chk("R7 no erase after abort", quiet, 0);
    arm();
    write_cmd(3, 8'h30);
    measure(tc, bc, m);
    chk("R7 pending cleared", m, 8'h08);

    // R3: late restart
    arm();
    write_cmd(2, 8'h30);
    repeat (W - 5) @(negedge clk);
    chk("R3 still in window", tmr_active, 1);
    write_cmd(5, 8'h30);
    measure(tc, bc, m);
    chk("R3 restarted window", tc, W);
    chk("R3 combined mask", m, 8'h24);

    // R8 / R9: commands during erase, polling
    arm();
    write_cmd(3, 8'h30);
    @(negedge clk);
    addr = sa(3); #0.5;
    chk("R9 poll high in window", poll_dq7, 1);
    while (tmr_active === 1'b1) @(negedge clk);
    bcnt = busy ? 1 : 0;
    addr = sa(3); #0.5;
    chk("R9 poll low in erased sector", poll_dq7, 0);
    addr = sa(0); #0.5;
    chk("R9 poll high elsewhere", poll_dq7, 1);
    setup_ok = 1'b1;
    tick(); setup_ok = 1'b0; addr = sa(6); we_n = 1'b0;
    tick(); wdata = 8'h30; we_n = 1'b1;
    tick();
    chk("R8 mask unchanged", erase_mask, 8'h08);
    for (int i = 0; i < 40; i++) tick();
    chk("R8 erase length unchanged", bcnt, E);
    chk("R8 no window afterwards", tmr_active, 0);
    chk("R9 poll high after erase", poll_dq7, 1);

    // R1: reset during erase
    arm();
    write_cmd(0, 8'h30);
    @(negedge clk);
    while (tmr_active === 1'b1) @(negedge clk);
    chk("R1 erase running before reset", busy, 1);
    rst_n = 1'b0; #0.5;
    chk("R1 reset mid-erase busy", busy, 0);
    chk("R1 reset mid-erase mask", erase_mask, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule